// File: doc/BRIEF.md
# Modulo-Scheduled Loop Control Unit

This block sequences a reconfigurable compute array through a software-pipelined loop. Before a run, the host fills a small store of control words through a write port. It also fills a kernel table. Each table entry gives four pointers into the store: where the ramp-up section begins, where the repeating body begins, where the body ends, and where the drain section ends. To run a loop, the host selects a kernel, supplies the trip count and pulses start.

While running, the unit steps a program counter by one word every clock cycle. The ramp-up words play once. The body section then replays a number of times that depends on the trip count, and the drain words play once. In every active cycle the unit drives the fields of the current word to the array: a context id, one disable bit per cell for cells sitting in a pipeline bubble, write enables for the memory cells, and a selector naming the cell output routed back to the host data bus. When the last drain word has been issued, a done level rises so that a host waiting on the loop can continue.

A mode input separates data-transfer phases from execution. While that input is high, start requests are not honoured.

Top module: `lcu_loop_ctrl`

## Requirements
- R1: After reset, busy and done are 0, cell_dis is all ones, and mem_we, ctx_id and out_sel are 0.
- R2: A start pulse with iter_count > 0, dma_mode low and busy low is accepted. In the cycle after the accepting edge, busy is 1 and the word at the kernel's ramp-up pointer is on the outputs. One further word follows each cycle.
- R3: The ramp-up words, from the ramp-up pointer up to one below the body pointer, are issued exactly once, in address order. Let D be the ramp-up length (body pointer minus ramp-up pointer); D may be zero.
- R4: When iter_count > D, the body words (body pointer through body-end pointer, inclusive) are issued iter_count − D times back to back, jumping from the body-end word straight to the body-start word.
- R5: When 0 < iter_count ≤ D, the body is issued exactly once.
- R6: After the final body pass, the drain words (body-end + 1 through drain-end, inclusive) are issued once. In the next cycle busy is 0. If drain-end equals body-end, the drain is empty and the run ends right after the last body pass.
- R7: An accepted start with iter_count = 0 issues no words. busy stays 0 and done is 1 in the following cycle.
- R8: done rises in the first idle cycle after a run and holds until a start with iter_count > 0 is accepted, which clears it in the next cycle. done and busy are never both 1.
- R9: Word layout: ctx_id is bits [3:0], cell_dis bits [11:4], mem_we bits [13:12] and out_sel bits [16:14]. Each field is driven unchanged while busy.
- R10: While not busy, cell_dis is all ones and mem_we, ctx_id and out_sel are 0.
- R11: While dma_mode is 1, start is ignored: busy stays 0 and done keeps its value.
- R12: While busy, writes to the word store and to the kernel table are ignored, and a further start pulse has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dma_mode | input | 1 | High during data-transfer phases; blocks start |
| start | input | 1 | Request to begin a loop run |
| kernel_sel | input | 2 | Kernel table entry used by start |
| iter_count | input | 16 | Loop trip count sampled with start |
| cw_we | input | 1 | Word store write enable |
| cw_addr | input | 4 | Word store write address |
| cw_wdata | input | 17 | Word store write data |
| kd_we | input | 1 | Kernel table write enable |
| kd_idx | input | 2 | Kernel table entry written |
| kd_start | input | 4 | Ramp-up start pointer |
| kd_ss_start | input | 4 | Body start pointer |
| kd_ss_end | input | 4 | Body end pointer (inclusive) |
| kd_ep_end | input | 4 | Drain end pointer (inclusive) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run has completed |
| ctx_id | output | 4 | Context to execute this cycle |
| cell_dis | output | 8 | Per-cell bubble disable |
| mem_we | output | 2 | Memory cell write enables |
| out_sel | output | 3 | Cell output routed to the host bus |

## Verification
The bench keeps its own list of expected addresses for every run and compares all four output fields against it cycle by cycle. A design that counted passes off by one, or that jumped back one word early or late, therefore shows up as a wrong word at a specific cycle. The cases covered are: no ramp-up, an empty drain, a one-word body, a trip count equal to and below the ramp-up length, and a zero count. A wrong short path would either underflow the pass count into a very long run or skip the body entirely. Writes and a second start pulse are injected mid-run, and the same kernels are run again afterwards. A design that let them through would emit corrupted words or change kernel during the run. The bench also checks that done stays high while idle, clears on the next run, and ignores start in transfer mode.

// File: rtl/lcu_pkg.sv
// Package: shared types and helpers for the loop control unit.
// Assumes trip counts and pointer distances fit in 32 bits.
package lcu_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Number of body passes for a trip count and ramp-up depth; minimum one.
    function automatic int unsigned body_passes(input int unsigned cnt,
                                                input int unsigned depth);
        return (cnt > depth) ? (cnt - depth) : 32'd1;
    endfunction

endpackage

// File: rtl/lcu_cw_store.sv
// Module: control word store and kernel pointer table.
// Holds DEPTH words of CW_W bits and NUM_KERNELS pointer sets. Writes are
// blocked while a run is active. Word read is asynchronous at the program
// counter; the table is read asynchronously at the selected kernel.
// Assumes DEPTH is a power of two.
module lcu_cw_store #(
    parameter int DEPTH       = 16,
    parameter int CW_W        = 17,
    parameter int NUM_KERNELS = 4,
    localparam int AW         = $clog2(DEPTH),
    localparam int KID_W      = (NUM_KERNELS > 1) ? $clog2(NUM_KERNELS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             cw_we,
    input  logic [AW-1:0]    cw_addr,
    input  logic [CW_W-1:0]  cw_wdata,
    input  logic             kd_we,
    input  logic [KID_W-1:0] kd_idx,
    input  logic [AW-1:0]    kd_start,
    input  logic [AW-1:0]    kd_ss_start,
    input  logic [AW-1:0]    kd_ss_end,
    input  logic [AW-1:0]    kd_ep_end,
    input  logic [AW-1:0]    rd_pc,
    output logic [CW_W-1:0]  rd_word,
    input  logic [KID_W-1:0] rd_kid,
    output logic [AW-1:0]    rd_start,
    output logic [AW-1:0]    rd_ss_start,
    output logic [AW-1:0]    rd_ss_end,
    output logic [AW-1:0]    rd_ep_end
);

    localparam int PTRS_W = 4 * AW;

    logic [DEPTH-1:0][CW_W-1:0]         words_q;
    logic [NUM_KERNELS-1:0][PTRS_W-1:0] ptrs_q;

    // Word store write, gated by the run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q <= '0;
        end else if (cw_we && !busy) begin
            words_q[cw_addr] <= cw_wdata;
        end
    end

    // Kernel table write, gated by the run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptrs_q <= '0;
        end else if (kd_we && !busy) begin
            ptrs_q[kd_idx] <= {kd_ep_end, kd_ss_end, kd_ss_start, kd_start};
        end
    end

    // Asynchronous read ports.
    always_comb begin
        rd_word     = words_q[rd_pc];
        rd_start    = ptrs_q[rd_kid][0*AW +: AW];
        rd_ss_start = ptrs_q[rd_kid][1*AW +: AW];
        rd_ss_end   = ptrs_q[rd_kid][2*AW +: AW];
        rd_ep_end   = ptrs_q[rd_kid][3*AW +: AW];
    end

    // R12
    word_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(words_q));
    // R12
    table_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptrs_q));

endmodule

// File: rtl/lcu_seq.sv
// Module: program counter sequencer.
// Plays ramp-up once, replays the body a count-dependent number of times and
// plays the drain once. Pointers are latched at start so that table updates
// cannot disturb a run. Assumes start <= ss_start <= ss_end <= ep_end.
module lcu_seq
    import lcu_pkg::*;
#(
    parameter int AW    = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_mode,
    input  logic             start,
    input  logic [CNT_W-1:0] iter_count,
    input  logic [AW-1:0]    d_start,
    input  logic [AW-1:0]    d_ss_start,
    input  logic [AW-1:0]    d_ss_end,
    input  logic [AW-1:0]    d_ep_end,
    output logic [AW-1:0]    pc,
    output logic             busy,
    output logic             done
);

    seq_state_e       state_q;
    logic [AW-1:0]    pc_q;
    logic [AW-1:0]    ss_start_q;
    logic [AW-1:0]    ss_end_q;
    logic [AW-1:0]    ep_end_q;
    logic [CNT_W-1:0] pass_q;
    logic             done_q;

    logic             start_ok;
    logic [AW-1:0]    depth;
    logic [CNT_W-1:0] first_passes;
    logic             at_body_end;
    logic             at_drain_end;

    // Start acceptance and pass count for the new run.
    always_comb begin
        start_ok     = start && !dma_mode && (state_q == SEQ_IDLE);
        depth        = d_ss_start - d_start;
        first_passes = CNT_W'(body_passes(32'(iter_count), 32'(depth)));
        at_body_end  = (pass_q != '0) && (pc_q == ss_end_q);
        at_drain_end = (pass_q == '0) && (pc_q == ep_end_q);
    end

    // Run state, program counter, remaining passes and done level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_IDLE;
            pc_q       <= '0;
            ss_start_q <= '0;
            ss_end_q   <= '0;
            ep_end_q   <= '0;
            pass_q     <= '0;
            done_q     <= 1'b0;
        end else if (state_q == SEQ_IDLE) begin
            if (start_ok) begin
                if (iter_count == '0) begin
                    done_q <= 1'b1;
                end else begin
                    state_q    <= SEQ_RUN;
                    done_q     <= 1'b0;
                    pc_q       <= d_start;
                    ss_start_q <= d_ss_start;
                    ss_end_q   <= d_ss_end;
                    ep_end_q   <= d_ep_end;
                    pass_q     <= first_passes;
                end
            end
        end else begin
            if (at_body_end) begin
                if (pass_q > CNT_W'(1)) begin
                    pc_q   <= ss_start_q;
                    pass_q <= pass_q - CNT_W'(1);
                end else if (ss_end_q == ep_end_q) begin
                    state_q <= SEQ_IDLE;
                    done_q  <= 1'b1;
                    pass_q  <= '0;
                end else begin
                    pc_q   <= pc_q + AW'(1);
                    pass_q <= '0;
                end
            end else if (at_drain_end) begin
                state_q <= SEQ_IDLE;
                done_q  <= 1'b1;
            end else begin
                pc_q <= pc_q + AW'(1);
            end
        end
    end

    assign pc   = pc_q;
    assign busy = (state_q == SEQ_RUN);
    assign done = done_q;

    // R7
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ok && iter_count == '0) |=> (done && !busy));
    // R8
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
    // R11
    dma_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dma_mode && !busy) |=> !busy);
    // R6
    pc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pc_q <= ep_end_q));
    // R4
    body_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && at_body_end && pass_q > CNT_W'(1)) |=> (busy && pc_q == ss_start_q));
    // R12
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(ss_start_q) && $stable(ep_end_q)));

endmodule

// File: rtl/lcu_ctl_drive.sv
// Module: splits the active control word into array control fields.
// When no run is active, every cell is disabled and all other fields are 0.
// Assumes the word layout ctx | cell_dis | mem_we | out_sel from bit 0 up.
module lcu_ctl_drive #(
    parameter int CTX_W     = 4,
    parameter int NUM_CELLS = 8,
    parameter int NUM_MEMS  = 2,
    parameter int SEL_W     = 3,
    localparam int DIS_LO   = CTX_W,
    localparam int WE_LO    = DIS_LO + NUM_CELLS,
    localparam int SEL_LO   = WE_LO + NUM_MEMS,
    localparam int CW_W     = SEL_LO + SEL_W
) (
    input  logic                 busy,
    input  logic [CW_W-1:0]      word,
    output logic [CTX_W-1:0]     ctx_id,
    output logic [NUM_CELLS-1:0] cell_dis,
    output logic [NUM_MEMS-1:0]  mem_we,
    output logic [SEL_W-1:0]     out_sel
);

    // Per-cell disable: bubble bit while running, forced off while idle.
    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
        assign cell_dis[c] = busy ? word[DIS_LO + c] : 1'b1;
    end

    // Per-memory write enable: only while running.
    for (genvar m = 0; m < NUM_MEMS; m++) begin : g_mem
        assign mem_we[m] = busy & word[WE_LO + m];
    end

    // Context and bus selector fields.
    always_comb begin
        ctx_id  = busy ? word[0 +: CTX_W]       : '0;
        out_sel = busy ? word[SEL_LO +: SEL_W]  : '0;
    end

endmodule

// File: rtl/lcu_loop_ctrl.sv
// Module: loop control unit top. Connects the word store, the sequencer
// and the field driver. One word is issued per cycle while a run is active.
// Assumes the kernel table holds ordered pointers before start is issued.
module lcu_loop_ctrl #(
    parameter int DEPTH       = 16,
    parameter int NUM_KERNELS = 4,
    parameter int CNT_W       = 16,
    parameter int CTX_W       = 4,
    parameter int NUM_CELLS   = 8,
    parameter int NUM_MEMS    = 2,
    parameter int SEL_W       = 3,
    localparam int AW         = $clog2(DEPTH),
    localparam int KID_W      = (NUM_KERNELS > 1) ? $clog2(NUM_KERNELS) : 1,
    localparam int CW_W       = CTX_W + NUM_CELLS + NUM_MEMS + SEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dma_mode,
    input  logic                 start,
    input  logic [KID_W-1:0]     kernel_sel,
    input  logic [CNT_W-1:0]     iter_count,
    input  logic                 cw_we,
    input  logic [AW-1:0]        cw_addr,
    input  logic [CW_W-1:0]      cw_wdata,
    input  logic                 kd_we,
    input  logic [KID_W-1:0]     kd_idx,
    input  logic [AW-1:0]        kd_start,
    input  logic [AW-1:0]        kd_ss_start,
    input  logic [AW-1:0]        kd_ss_end,
    input  logic [AW-1:0]        kd_ep_end,
    output logic                 busy,
    output logic                 done,
    output logic [CTX_W-1:0]     ctx_id,
    output logic [NUM_CELLS-1:0] cell_dis,
    output logic [NUM_MEMS-1:0]  mem_we,
    output logic [SEL_W-1:0]     out_sel
);

    logic [AW-1:0]   pc;
    logic [CW_W-1:0] cur_word;
    logic [AW-1:0]   p_start;
    logic [AW-1:0]   p_ss_start;
    logic [AW-1:0]   p_ss_end;
    logic [AW-1:0]   p_ep_end;
    logic            run;

    lcu_cw_store #(
        .DEPTH       (DEPTH),
        .CW_W        (CW_W),
        .NUM_KERNELS (NUM_KERNELS)
    ) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy        (run),
        .cw_we       (cw_we),
        .cw_addr     (cw_addr),
        .cw_wdata    (cw_wdata),
        .kd_we       (kd_we),
        .kd_idx      (kd_idx),
        .kd_start    (kd_start),
        .kd_ss_start (kd_ss_start),
        .kd_ss_end   (kd_ss_end),
        .kd_ep_end   (kd_ep_end),
        .rd_pc       (pc),
        .rd_word     (cur_word),
        .rd_kid      (kernel_sel),
        .rd_start    (p_start),
        .rd_ss_start (p_ss_start),
        .rd_ss_end   (p_ss_end),
        .rd_ep_end   (p_ep_end)
    );

    lcu_seq #(
        .AW    (AW),
        .CNT_W (CNT_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dma_mode   (dma_mode),
        .start      (start),
        .iter_count (iter_count),
        .d_start    (p_start),
        .d_ss_start (p_ss_start),
        .d_ss_end   (p_ss_end),
        .d_ep_end   (p_ep_end),
        .pc         (pc),
        .busy       (run),
        .done       (done)
    );

    lcu_ctl_drive #(
        .CTX_W     (CTX_W),
        .NUM_CELLS (NUM_CELLS),
        .NUM_MEMS  (NUM_MEMS),
        .SEL_W     (SEL_W)
    ) drive_i (
        .busy     (run),
        .word     (cur_word),
        .ctx_id   (ctx_id),
        .cell_dis (cell_dis),
        .mem_we   (mem_we),
        .out_sel  (out_sel)
    );

    assign busy = run;

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (mem_we == '0 && (&cell_dis) && ctx_id == '0));
    // R9
    active_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (ctx_id == cur_word[CTX_W-1:0]));

endmodule

// File: tb/lcu_loop_ctrl_tb.sv
// Bench: vector table of (kernel, count) runs walked by one loop, then
// directed tests for reset, zero count, done holding, transfer mode and
// writes or start pulses injected mid-run.
module lcu_loop_ctrl_tb_top;

    localparam int CW_W = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dma_mode = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  kernel_sel = '0;
    logic [15:0] iter_count = '0;
    logic        cw_we = 1'b0;
    logic [3:0]  cw_addr = '0;
    logic [16:0] cw_wdata = '0;
    logic        kd_we = 1'b0;
    logic [1:0]  kd_idx = '0;
    logic [3:0]  kd_start = '0, kd_ss_start = '0, kd_ss_end = '0, kd_ep_end = '0;
    logic        busy, done;
    logic [3:0]  ctx_id;
    logic [7:0]  cell_dis;
    logic [1:0]  mem_we;
    logic [2:0]  out_sel;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Kernel pointers as known to the bench: start, body start, body end, drain end
    int k_st [4] = '{0, 8, 10, 0};
    int k_ss [4] = '{2, 8, 13, 0};
    int k_se [4] = '{4, 9, 13, 0};
    int k_ee [4] = '{6, 9, 15, 0};

    int exp_addr [64];
    int exp_len;

    typedef struct packed {
        logic [1:0]  kid;
        logic [15:0] cnt;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{2'd0, 16'd5},  // D=2 -> 3 body passes
        '{2'd0, 16'd2},  // count equals ramp-up depth
        '{2'd0, 16'd1},  // count below depth
        '{2'd1, 16'd4},  // no ramp-up, empty drain
        '{2'd2, 16'd7},  // one-word body
        '{2'd2, 16'd3},  // count equals depth
        '{2'd1, 16'd1},
        '{2'd2, 16'd4},
        '{2'd0, 16'd3}
    };

    lcu_loop_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .start(start),
        .kernel_sel(kernel_sel), .iter_count(iter_count),
        .cw_we(cw_we), .cw_addr(cw_addr), .cw_wdata(cw_wdata),
        .kd_we(kd_we), .kd_idx(kd_idx), .kd_start(kd_start),
        .kd_ss_start(kd_ss_start), .kd_ss_end(kd_ss_end), .kd_ep_end(kd_ep_end),
        .busy(busy), .done(done), .ctx_id(ctx_id), .cell_dis(cell_dis),
        .mem_we(mem_we), .out_sel(out_sel)
    );

    always #4 clk = ~clk;

    // Word content used for every address: unique per address
    function automatic logic [16:0] word_of(input int a);
        logic [7:0] dis;
        logic [1:0] we;
        logic [2:0] sel;
        dis = 8'((a * 29 + 5) & 8'hFF);
        we  = 2'((a + 1) & 3);
        sel = 3'((a * 5) & 7);
        return {sel, we, dis, 4'(a)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected address sequence from the requirements (R3, R4, R5, R6)
    task automatic build_exp(input int kid, input int cnt);
        int d, p;
        exp_len = 0;
        if (cnt == 0) return;
        d = k_ss[kid] - k_st[kid];
        p = (cnt > d) ? cnt - d : 1;
        for (int a = k_st[kid]; a < k_ss[kid]; a++) begin exp_addr[exp_len] = a; exp_len++; end
        for (int r = 0; r < p; r++)
            for (int a = k_ss[kid]; a <= k_se[kid]; a++) begin exp_addr[exp_len] = a; exp_len++; end
        for (int a = k_se[kid] + 1; a <= k_ee[kid]; a++) begin exp_addr[exp_len] = a; exp_len++; end
    endtask

    // Launch one run and compare every issued word; optional mid-run disturbance
    task automatic run_check(input int kid, input int cnt, input bit disturb);
        logic [16:0] w;
        build_exp(kid, cnt);
        @(negedge clk);
        kernel_sel = 2'(kid); iter_count = 16'(cnt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (cnt != 0) check(done == 1'b0, "R8 done cleared", int'(done), 0);
        for (int k = 0; k < exp_len; k++) begin
            w = word_of(exp_addr[k]);
            check(busy == 1'b1, "R2 busy", int'(busy), 1);
            check(ctx_id == w[3:0], "R9 ctx_id", int'(ctx_id), int'(w[3:0]));
            check(cell_dis == w[11:4], "R9 cell_dis", int'(cell_dis), int'(w[11:4]));
            check(mem_we == w[13:12], "R9 mem_we", int'(mem_we), int'(w[13:12]));
            check(out_sel == w[16:14], "R9 out_sel", int'(out_sel), int'(w[16:14]));
            if (disturb && k == 2) begin
                // R12: all of these must be ignored
                start = 1'b1; kernel_sel = 2'd1; iter_count = 16'd9;
                cw_we = 1'b1; cw_addr = 4'(exp_addr[4]); cw_wdata = 17'h1FFFF;
                kd_we = 1'b1; kd_idx = 2'(kid);
                kd_start = 4'd15; kd_ss_start = 4'd15; kd_ss_end = 4'd15; kd_ep_end = 4'd15;
            end else begin
                start = 1'b0; cw_we = 1'b0; kd_we = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0; cw_we = 1'b0; kd_we = 1'b0;
        check(busy == 1'b0, "R6 idle after drain", int'(busy), 0);
        check(done == 1'b1, "R8 done after run", int'(done), 1);
        check(mem_we == 2'b00 && cell_dis == 8'hFF, "R10 idle fields",
              int'({mem_we, cell_dis}), 32'h0FF);
    endtask

    // Watchdog: a hung run counts as a failure and still reaches the summary
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0 && done == 1'b0, "R1 busy/done", int'({busy, done}), 0);
        check(cell_dis == 8'hFF, "R1 cell_dis", int'(cell_dis), 32'hFF);
        check(mem_we == 0 && ctx_id == 0 && out_sel == 0, "R1 fields",
              int'({mem_we, ctx_id, out_sel}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Load word store and kernel table
        for (int a = 0; a < 16; a++) begin
            cw_we = 1'b1; cw_addr = 4'(a); cw_wdata = word_of(a);
            @(negedge clk);
        end
        cw_we = 1'b0;
        for (int k = 0; k < 4; k++) begin
            kd_we = 1'b1; kd_idx = 2'(k);
            kd_start = 4'(k_st[k]); kd_ss_start = 4'(k_ss[k]);
            kd_ss_end = 4'(k_se[k]); kd_ep_end = 4'(k_ee[k]);
            @(negedge clk);
        end
        kd_we = 1'b0;

        // Vector table walk (R2..R6, R9)
        foreach (VECS[i]) begin
            run_check(int'(VECS[i].kid), int'(VECS[i].cnt), 1'b0);
        end

        // R8: done holds while idle
        repeat (4) @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, "R8 done held", int'({done, busy}), 2);

        // R11: start ignored in transfer mode
        dma_mode = 1'b1; kernel_sel = 2'd0; iter_count = 16'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R11 no run in dma mode", int'(busy), 0);
        check(done == 1'b1, "R11 done unchanged", int'(done), 1);
        check(cell_dis == 8'hFF, "R11 cells disabled", int'(cell_dis), 32'hFF);
        dma_mode = 1'b0;

        // R7: zero count
        run_check(0, 0, 1'b0);
        check(ctx_id == 4'd0, "R7 no words", int'(ctx_id), 0);

        // R12: disturbed run, then clean reruns prove stores untouched
        run_check(0, 5, 1'b1);
        run_check(0, 5, 1'b0);
        run_check(2, 4, 1'b1);
        run_check(2, 4, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule